// File: doc/BRIEF.md
# Byte-Loaded Scan Pulse Down-Counter

This block is a 32-bit binary down-counter that fixes how many scan clock pulses a serial test master issues. The host sets the start value through an 8-bit port by writing four bytes in a row to one address. The bytes arrive least significant first. A 2-bit write pointer tracks which byte comes next. The assembled value replaces the count only when the fourth byte lands. While the pointer is partway through a value, the old count stays frozen.

Once its mode enable bit is set, the counter steps down by one for every issued scan clock pulse. It stops at zero and never wraps. The terminal-count output is used to hold the scan clock off. Reaching zero by a decrement also does two more things: it fires a one-cycle trigger, which can force a test mode select line high, and it sets an interrupt flag that stays set until the host clears it. Decoding of the host bus is outside this block.

Top module: `scanPulseCounter`

## Requirements
- R1: After the asynchronous active-low reset, the count is 0, the write pointer is 0, `irqFlag` is 0 and `tcTrigger` is 0.
- R2: Byte writes go least significant byte first. The byte written at pointer k becomes count bits [8k+7:8k]. The count changes only on the clock edge that takes the fourth byte; the new value holds from the cycle after.
- R3: The write pointer goes up by one on each byte write and returns to 0 after the fourth byte. The next write starts a new value at the least significant byte.
- R4: When `cntEnable` is 1, the write pointer is 0, `byteWrEn` is 0 and the count is not 0, each cycle with `pulseStb` high lowers the count by exactly one.
- R5: While `cntEnable` is 0, `pulseStb` has no effect on the count, and `termCount` is 0.
- R6: `termCount` is 1 exactly when `cntEnable` is 1 and the count is 0. At zero, further pulses leave the count at 0; it does not wrap.
- R7: `tcTrigger` is high for one cycle, in the first cycle after a decrement takes the count from 1 to 0. Loading a value of 0 does not fire it.
- R8: The same 1-to-0 decrement sets `irqFlag`. The flag stays set until a cycle with `irqClr` high clears it. If the set and the clear fall in the same cycle, the set wins.
- R9: While the write pointer is not 0, and in any cycle with `byteWrEn` high, `pulseStb` does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteWrEn | input | 1 | Strobe that writes one byte of the start value |
| byteData | input | 8 | Byte written with `byteWrEn` |
| pulseStb | input | 1 | One scan clock pulse was issued this cycle |
| cntEnable | input | 1 | Mode bit that lets the counter take part in operations |
| irqClr | input | 1 | Host clear of the interrupt flag |
| termCount | output | 1 | Counter enabled and at zero; used to hold off the scan clock |
| irqFlag | output | 1 | Sticky terminal-count interrupt |
| tcTrigger | output | 1 | One-cycle pulse when a decrement reaches zero; drives the test mode select force |

## Verification
On every cycle, the assertions check the following:
- a decrement moves the count by exactly one;
- a count of zero holds at zero;
- the count stays frozen while a load is partway through;
- the write pointer wraps to 0 after the fourth byte;
- the interrupt flag is sticky and the trigger lasts one cycle.

Other behaviours can only be shown by the bench's scenarios, which compare against a reference model on every clock:
- the byte order, through how many pulses a loaded value takes to reach zero;
- that a loaded zero does not fire the trigger;
- that a set wins over a clear in the same cycle;
- that pulses are ignored while the counter is disabled.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Strobes that the control module sends to the datapath each cycle.
  typedef struct packed {
    logic loadByte;    // store byteData into the lane selected by the pointer
    logic commitLoad;  // final byte: replace the count with the assembled value
    logic decrement;   // lower the count by one
  } scpStrobes_t;
endpackage

// File: rtl/scpDatapath.sv
module scpDatapath
  import scp_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  scpStrobes_t                  strb,
  input  logic [$clog2(NUM_BYTES)-1:0] wrPtr,
  input  logic [BYTE_W-1:0]            byteData,
  output logic                         cntIsZero,
  output logic                         cntIsOne
);
  localparam int CNT_W = BYTE_W * NUM_BYTES;
  localparam int PTR_W = $clog2(NUM_BYTES);

  logic [CNT_W-1:0] assembled;
  logic [CNT_W-1:0] cntQ;

  // Holding registers for every byte except the last one.
  // The last byte goes straight from byteData into the count.
  genvar g;
  for (g = 0; g < NUM_BYTES - 1; g++) begin : gLane
    logic [BYTE_W-1:0] laneReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneReg <= '0;
      else if (strb.loadByte && wrPtr == PTR_W'(g))
        laneReg <= byteData;
    end
    assign assembled[g*BYTE_W +: BYTE_W] = laneReg;
  end
  assign assembled[CNT_W-1 -: BYTE_W] = byteData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntQ <= '0;
    else if (strb.commitLoad)
      cntQ <= assembled;
    else if (strb.decrement)
      cntQ <= cntQ - CNT_W'(1);
  end

  assign cntIsZero = (cntQ == '0);
  assign cntIsOne  = (cntQ == CNT_W'(1));

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.decrement && !strb.commitLoad |=> cntQ == $past(cntQ) - CNT_W'(1)); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cntIsZero && !strb.commitLoad |=> cntIsZero); // R6

  AST_LOAD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr != '0 && !strb.commitLoad |=> $stable(cntQ)); // R9
endmodule

// File: rtl/scpCtrl.sv
module scpCtrl
  import scp_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         byteWrEn,
  input  logic                         pulseStb,
  input  logic                         cntEnable,
  input  logic                         irqClr,
  input  logic                         cntIsZero,
  input  logic                         cntIsOne,
  output scpStrobes_t                  strb,
  output logic [$clog2(NUM_BYTES)-1:0] wrPtr,
  output logic                         irqFlag,
  output logic                         tcTrigger
);
  localparam int PTR_W = $clog2(NUM_BYTES);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_BYTES - 1);

  logic loadIdle;
  logic reachZero;

  assign loadIdle        = (wrPtr == '0) && !byteWrEn;
  assign strb.loadByte   = byteWrEn && (wrPtr != LAST_PTR);
  assign strb.commitLoad = byteWrEn && (wrPtr == LAST_PTR);
  assign strb.decrement  = pulseStb && cntEnable && loadIdle && !cntIsZero;
  assign reachZero       = strb.decrement && cntIsOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wrPtr <= '0;
    else if (byteWrEn)
      wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag   <= 1'b0;
      tcTrigger <= 1'b0;
    end else begin
      tcTrigger <= reachZero;
      if (reachZero)
        irqFlag <= 1'b1;
      else if (irqClr)
        irqFlag <= 1'b0;
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    byteWrEn && wrPtr == LAST_PTR |=> wrPtr == '0); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !irqClr |=> irqFlag); // R8

  AST_TRIG_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    tcTrigger |-> irqFlag); // R8

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tcTrigger |=> !tcTrigger); // R7
endmodule

// File: rtl/scanPulseCounter.sv
module scanPulseCounter
  import scp_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteWrEn,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              pulseStb,
  input  logic              cntEnable,
  input  logic              irqClr,
  output logic              termCount,
  output logic              irqFlag,
  output logic              tcTrigger
);
  localparam int PTR_W = $clog2(NUM_BYTES);

  scpStrobes_t      strb;
  logic [PTR_W-1:0] wrPtr;
  logic             cntIsZero;
  logic             cntIsOne;

  scpCtrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteWrEn  (byteWrEn),
    .pulseStb  (pulseStb),
    .cntEnable (cntEnable),
    .irqClr    (irqClr),
    .cntIsZero (cntIsZero),
    .cntIsOne  (cntIsOne),
    .strb      (strb),
    .wrPtr     (wrPtr),
    .irqFlag   (irqFlag),
    .tcTrigger (tcTrigger)
  );

  scpDatapath #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrPtr     (wrPtr),
    .byteData  (byteData),
    .cntIsZero (cntIsZero),
    .cntIsOne  (cntIsOne)
  );

  assign termCount = cntEnable && cntIsZero;
endmodule

// File: tb/scanPulseCounter_tb.sv
`timescale 1ns/1ps
module scanPulseCounter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteWrEn = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       pulseStb = 1'b0;
  logic       cntEnable = 1'b0;
  logic       irqClr = 1'b0;
  logic       termCount, irqFlag, tcTrigger;

  int compared = 0;
  int mismatched = 0;

  // Reference model state
  logic [7:0]  pend[$];
  logic [31:0] mCnt = 32'd0;
  logic        mIrq = 1'b0;
  logic        mTrig = 1'b0;

  always #5 clk = ~clk;

  scanPulseCounter u_dut (
    .clk(clk), .rstN(rstN), .byteWrEn(byteWrEn), .byteData(byteData),
    .pulseStb(pulseStb), .cntEnable(cntEnable), .irqClr(irqClr),
    .termCount(termCount), .irqFlag(irqFlag), .tcTrigger(tcTrigger)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive inputs after the falling edge, update the model at the
  // rising edge, compare the outputs 1 ns after that edge.
  task automatic step(input string tag, input logic wr, input logic [7:0] d,
                      input logic pl, input logic en, input logic clr);
    logic ev;
    @(negedge clk);
    byteWrEn = wr; byteData = d; pulseStb = pl; cntEnable = en; irqClr = clr;
    @(posedge clk);
    ev = 1'b0;
    if (wr) begin
      pend.push_back(d);
      if (pend.size() == 4) begin
        mCnt = {pend[3], pend[2], pend[1], pend[0]};
        pend.delete();
      end
    end else if (pl && en && pend.size() == 0 && mCnt != 0) begin
      if (mCnt == 1) ev = 1'b1;
      mCnt = mCnt - 1;
    end
    mTrig = ev;
    if (ev) mIrq = 1'b1;
    else if (clr) mIrq = 1'b0;
    #1;
    chk(tag, "termCount", termCount, en && (mCnt == 0));
    chk(tag, "irqFlag", irqFlag, mIrq);
    chk(tag, "tcTrigger", tcTrigger, mTrig);
  endtask

  task automatic load32(input string tag, input logic [31:0] v, input logic en);
    for (int i = 0; i < 4; i++) step(tag, 1'b1, v[i*8 +: 8], 1'b0, en, 1'b0);
  endtask

  task automatic pulses(input string tag, input int n, input logic en);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 8'h00, 1'b1, en, 1'b0);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irqFlag in reset", irqFlag, 1'b0);
    chk("R1", "tcTrigger in reset", tcTrigger, 1'b0);
    @(negedge clk); rstN = 1'b1;
    step("R1", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R1", "termCount zero count after reset", termCount, 1'b1);

    // R2: LSB-first; 0x00000100 needs 256 pulses
    load32("R2", 32'h0000_0100, 1'b1);
    pulses("R2", 255, 1'b1);
    chk("R2", "not yet zero after 255", termCount, 1'b0);
    pulses("R2", 1, 1'b1);
    chk("R2", "zero after 256", termCount, 1'b1);
    chk("R7", "trigger on reaching zero", tcTrigger, 1'b1);
    chk("R8", "irq set on reaching zero", irqFlag, 1'b1);
    step("R7", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R7", "trigger one cycle only", tcTrigger, 1'b0);
    chk("R8", "irq sticky", irqFlag, 1'b1);

    // R6: pulses at zero hold at zero
    pulses("R6", 5, 1'b1);
    chk("R6", "holds at zero", termCount, 1'b1);
    step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R8", "irq cleared", irqFlag, 1'b0);

    // R9 and R3: partial load freezes the count, pulses during load ignored
    load32("R3", 32'h0000_0005, 1'b1);
    step("R9", 1'b1, 8'h03, 1'b1, 1'b1, 1'b0);
    pulses("R9", 3, 1'b1);
    chk("R9", "old count kept during partial load", termCount, 1'b0);
    step("R9", 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
    step("R9", 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
    step("R3", 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
    pulses("R3", 2, 1'b1);
    chk("R3", "new value 3 not yet zero", termCount, 1'b0);
    pulses("R4", 1, 1'b1);
    chk("R4", "zero after third pulse", termCount, 1'b1);

    // R5: disabled counter ignores pulses
    load32("R5", 32'h0000_0002, 1'b0);
    pulses("R5", 10, 1'b0);
    chk("R5", "termCount low while disabled", termCount, 1'b0);
    pulses("R5", 1, 1'b1);
    chk("R5", "one pulse left after enable", termCount, 1'b0);

    // R8: set wins over clear in the same cycle
    step("R8", 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R8", "set beats clear", irqFlag, 1'b1);
    step("R8", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);

    // R7: loading zero fires nothing
    load32("R7", 32'h0000_0000, 1'b1);
    chk("R7", "no trigger on loaded zero", tcTrigger, 1'b0);
    chk("R7", "no irq on loaded zero", irqFlag, 1'b0);

    // R4: large value with high bytes, partial countdown
    load32("R4", 32'hA500_0003, 1'b1);
    pulses("R4", 20, 1'b1);
    chk("R4", "large value not at zero", termCount, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule